// File: doc/BRIEF.md
# Base-Delta Cache Line Expander

This block turns a compressed cache line back into a full 32-byte line in a single registered stage. A compressed line arrives as a 4-bit encoding, a 64-bit base word, a per-element select mask and a packed payload of small signed deltas. For the six base/delta layouts, each output element is its delta sign-extended to the element width and added to one of two bases. The mask bit for that element chooses which base: the supplied base word, or an implicit base of zero. Every element is produced by its own adder, so all additions happen at the same time.

Three further encodings need no adder. An all-zero line produces zeros. A repeated-value line copies the 64-bit base word into every 8-byte slot. An uncompressed line forwards the payload unchanged. The expanded line is held in an output register and presented one clock after the input is taken. The block accepts a new line on every cycle and has no back-pressure on its output side.

Top module: `bdx_decomp`

## Requirements
- R1: After an input is accepted (in_valid and in_ready high at a rising edge), out_valid is 1 for the following cycle only. In any cycle that follows an edge with no accepted input, out_valid is 0. Synchronous reset clears out_valid and out_line to 0.
- R2: in_ready is 1 in every cycle in which rst is low.
- R3: Encoding 0 (all-zero line) yields out_line equal to 0.
- R4: Encoding 1 (repeated value) yields in_base copied into all four 8-byte slots of out_line.
- R5: Encodings 2 to 7 select the base/delta byte widths 8/1, 8/2, 8/4, 4/1, 4/2 and 2/1. Element i (i counted from 0) occupies out_line bits [i*8*EB +: 8*EB]. Its delta is taken from in_payload bits [i*8*DB +: 8*DB]. Its base is the low 8*EB bits of in_base. The result is base plus the sign-extended delta.
- R6: When in_zmask bit i is 1, element i uses a base of zero and equals its sign-extended delta. When the bit is 0, the element uses in_base.
- R7: Each element sum wraps modulo 2 to the power 8*EB. Carries never spill into the neighbouring element, and base bits above the element width have no effect.
- R8: Encoding 15 (uncompressed line) yields out_line equal to in_payload.
- R9: Encodings 8 to 14 are undefined and yield out_line equal to 0.
- R10: In a cycle with no accepted input, out_line keeps its previous value, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compressed line present |
| in_ready | output | 1 | Block can take a line this cycle |
| in_mode | input | 4 | Encoding of the compressed line |
| in_base | input | 64 | Base word; also the repeated value |
| in_zmask | input | 16 | One bit per element, 1 selects the zero base |
| in_payload | input | 256 | Packed deltas from bit 0 upward, or the raw line |
| out_valid | output | 1 | out_line holds a freshly expanded line |
| out_line | output | 256 | Expanded 32-byte line |

## Verification
The bench builds the block with its default 32-byte line, which gives a 16-bit mask and a 256-bit payload. At this size every layout is exercised at its real element count, from four 8-byte elements up to sixteen 2-byte elements. The 2/1 layout therefore uses every mask bit, and the 8/4 layout uses the full 128-bit delta field.

The chosen base and delta values reach the sign boundary of each delta width and the top of each element width. This makes wrap-around, negative immediates and ignored upper base bits visible on the output. Idle cycles carry changing data to show that the output register holds its value.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

    localparam int BASE_W    = 64;
    localparam int MODE_W    = 4;
    localparam int NUM_PAIRS = 6;

    typedef enum logic [MODE_W-1:0] {
        ENC_ZERO   = 4'd0,
        ENC_REPEAT = 4'd1,
        ENC_B8D1   = 4'd2,
        ENC_B8D2   = 4'd3,
        ENC_B8D4   = 4'd4,
        ENC_B4D1   = 4'd5,
        ENC_B4D2   = 4'd6,
        ENC_B2D1   = 4'd7,
        ENC_RAW    = 4'd15
    } enc_e;

    typedef struct packed {
        logic [7:0] base_bytes;
        logic [7:0] delta_bytes;
    } pair_t;

    // Layout k (0..5) corresponds to encoding k+2.
    function automatic pair_t pair_of(input int k);
        pair_t p;
        case (k)
            0:       p = '{base_bytes: 8'd8, delta_bytes: 8'd1};
            1:       p = '{base_bytes: 8'd8, delta_bytes: 8'd2};
            2:       p = '{base_bytes: 8'd8, delta_bytes: 8'd4};
            3:       p = '{base_bytes: 8'd4, delta_bytes: 8'd1};
            4:       p = '{base_bytes: 8'd4, delta_bytes: 8'd2};
            default: p = '{base_bytes: 8'd2, delta_bytes: 8'd1};
        endcase
        return p;
    endfunction

    function automatic int base_bytes_of(input int k);
        pair_t p;
        p = pair_of(k);
        return int'(p.base_bytes);
    endfunction

    function automatic int delta_bytes_of(input int k);
        pair_t p;
        p = pair_of(k);
        return int'(p.delta_bytes);
    endfunction

endpackage

// File: rtl/bdx_elem.sv
module bdx_elem #(
    parameter int EB = 8,
    parameter int DB = 1
) (
    input  logic [8*EB-1:0] base,
    input  logic            use_zero,
    input  logic [8*DB-1:0] delta,
    output logic [8*EB-1:0] value
);
    localparam int EW  = 8 * EB;
    localparam int DW  = 8 * DB;
    localparam int EXT = EW - DW;

    logic [EW-1:0] delta_ext;
    logic [EW-1:0] base_sel;

    always_comb begin
        delta_ext = {{EXT{delta[DW-1]}}, delta};
        base_sel  = use_zero ? '0 : base;
        value     = base_sel + delta_ext;
    end

endmodule

// File: rtl/bdx_lane_set.sv
module bdx_lane_set #(
    parameter int LINE_BYTES = 32,
    parameter int EB         = 8,
    parameter int DB         = 1
) (
    input  logic [8*EB-1:0]                   base,
    input  logic [LINE_BYTES/EB-1:0]          zmask,
    input  logic [(LINE_BYTES/EB)*8*DB-1:0]   deltas,
    output logic [8*LINE_BYTES-1:0]           line
);
    localparam int N  = LINE_BYTES / EB;
    localparam int EW = 8 * EB;
    localparam int DW = 8 * DB;

    for (genvar i = 0; i < N; i++) begin : g_elem
        bdx_elem #(.EB(EB), .DB(DB)) u_elem (
            .base    (base),
            .use_zero(zmask[i]),
            .delta   (deltas[i*DW +: DW]),
            .value   (line[i*EW +: EW])
        );
    end

endmodule

// File: rtl/bdx_select.sv
module bdx_select
    import bdx_pkg::*;
#(
    parameter int LINE_BYTES = 32
) (
    input  logic [MODE_W-1:0]                          mode,
    input  logic [BASE_W-1:0]                          base,
    input  logic [8*LINE_BYTES-1:0]                    raw,
    input  logic [NUM_PAIRS-1:0][8*LINE_BYTES-1:0]     pair_lines,
    output logic [8*LINE_BYTES-1:0]                    line
);
    localparam int LINE_W = 8 * LINE_BYTES;
    localparam int SLOTS  = LINE_BYTES / 8;

    always_comb begin
        case (mode)
            ENC_ZERO:   line = '0;
            ENC_REPEAT: line = {SLOTS{base}};
            ENC_B8D1:   line = pair_lines[0];
            ENC_B8D2:   line = pair_lines[1];
            ENC_B8D4:   line = pair_lines[2];
            ENC_B4D1:   line = pair_lines[3];
            ENC_B4D2:   line = pair_lines[4];
            ENC_B2D1:   line = pair_lines[5];
            ENC_RAW:    line = raw;
            default:    line = {LINE_W{1'b0}};
        endcase
    end

endmodule

// File: rtl/bdx_decomp.sv
module bdx_decomp
    import bdx_pkg::*;
#(
    parameter int LINE_BYTES = 32,
    parameter int LINE_W     = 8 * LINE_BYTES,
    parameter int MASK_W     = LINE_BYTES / 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [MODE_W-1:0]    in_mode,
    input  logic [BASE_W-1:0]    in_base,
    input  logic [MASK_W-1:0]    in_zmask,
    input  logic [LINE_W-1:0]    in_payload,
    output logic                 out_valid,
    output logic [LINE_W-1:0]    out_line
);
    logic [NUM_PAIRS-1:0][LINE_W-1:0] pair_lines;
    logic [LINE_W-1:0]                next_line;
    logic                             accept;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        localparam int EB = base_bytes_of(k);
        localparam int DB = delta_bytes_of(k);
        localparam int N  = LINE_BYTES / EB;
        bdx_lane_set #(.LINE_BYTES(LINE_BYTES), .EB(EB), .DB(DB)) u_lanes (
            .base  (in_base[8*EB-1:0]),
            .zmask (in_zmask[N-1:0]),
            .deltas(in_payload[N*8*DB-1:0]),
            .line  (pair_lines[k])
        );
    end

    bdx_select #(.LINE_BYTES(LINE_BYTES)) u_select (
        .mode      (in_mode),
        .base      (in_base),
        .raw       (in_payload),
        .pair_lines(pair_lines),
        .line      (next_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_line  <= '0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                out_line <= next_line;
            end
        end
    end

endmodule

// File: rtl/bdx_chk.sv
module bdx_chk #(
    parameter int LINE_BYTES = 32,
    parameter int LINE_W     = 8 * LINE_BYTES,
    parameter int MASK_W     = LINE_BYTES / 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [3:0]        in_mode,
    input logic [63:0]       in_base,
    input logic [MASK_W-1:0] in_zmask,
    input logic [LINE_W-1:0] in_payload,
    input logic              out_valid,
    input logic [LINE_W-1:0] out_line
);
    logic take;
    assign take = in_valid && in_ready;

    // R1
    a_r1_valid_after_take: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid);
    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !take |=> !out_valid);
    // R2
    a_r2_ready_out_of_reset: assert property (@(posedge clk) disable iff (rst)
        in_ready);
    // R3
    a_r3_zero_line: assert property (@(posedge clk) disable iff (rst)
        (take && in_mode == 4'd0) |=> (out_line == '0));
    // R4
    a_r4_repeat_slot0: assert property (@(posedge clk) disable iff (rst)
        (take && in_mode == 4'd1) |=> (out_line[63:0] == $past(in_base)));
    // R5
    a_r5_first_elem_8x1: assert property (@(posedge clk) disable iff (rst)
        (take && in_mode == 4'd2 && !in_zmask[0]) |=>
        (out_line[63:0] == $past(in_base + {{56{in_payload[7]}}, in_payload[7:0]})));
    // R6
    a_r6_zero_base_2x1: assert property (@(posedge clk) disable iff (rst)
        (take && in_mode == 4'd7 && in_zmask[0]) |=>
        (out_line[15:0] == $past({{8{in_payload[7]}}, in_payload[7:0]})));
    // R8
    a_r8_raw_pass: assert property (@(posedge clk) disable iff (rst)
        (take && in_mode == 4'd15) |=> (out_line == $past(in_payload)));
    // R9
    a_r9_undefined_zero: assert property (@(posedge clk) disable iff (rst)
        (take && in_mode >= 4'd8 && in_mode <= 4'd14) |=> (out_line == '0));
    // R10
    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(out_line));

endmodule

bind bdx_decomp bdx_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .in_base   (in_base),
    .in_zmask  (in_zmask),
    .in_payload(in_payload),
    .out_valid (out_valid),
    .out_line  (out_line)
);

// File: tb/bdx_decomp_bench.sv
module bdx_decomp_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [3:0]   in_mode = 4'd0;
    logic [63:0]  in_base = 64'd0;
    logic [15:0]  in_zmask = 16'd0;
    logic [255:0] in_payload = 256'd0;
    logic         out_valid;
    logic [255:0] out_line;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    string        cur_tag = "R1";
    string        exp_tag = "R1";
    logic         exp_valid = 1'b0;
    logic [255:0] exp_line = 256'd0;

    always #5 clk = ~clk;

    bdx_decomp u_bdx_decomp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_mode   (in_mode),
        .in_base   (in_base),
        .in_zmask  (in_zmask),
        .in_payload(in_payload),
        .out_valid (out_valid),
        .out_line  (out_line)
    );

    // Behavioural expansion written from the requirements.
    function automatic logic [255:0] model(input logic [3:0] m, input logic [63:0] b,
                                           input logic [15:0] z, input logic [255:0] p);
        logic [255:0] r;
        int eb;
        int db;
        r = '0;
        case (m)
            4'd0:  return '0;
            4'd1:  return {b, b, b, b};
            4'd15: return p;
            4'd2:  begin eb = 8; db = 1; end
            4'd3:  begin eb = 8; db = 2; end
            4'd4:  begin eb = 8; db = 4; end
            4'd5:  begin eb = 4; db = 1; end
            4'd6:  begin eb = 4; db = 2; end
            4'd7:  begin eb = 2; db = 1; end
            default: return '0;
        endcase
        for (int i = 0; i < 32 / eb; i++) begin
            logic [63:0] d;
            logic [63:0] s;
            d = '0;
            for (int k = 0; k < 8 * db; k++) d[k] = p[i*8*db + k];
            if (d[8*db-1]) for (int k = 8 * db; k < 64; k++) d[k] = 1'b1;
            s = (z[i] ? 64'd0 : b) + d;
            for (int k = 0; k < 8 * eb; k++) r[i*8*eb + k] = s[k];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_valid = 1'b0;
            exp_line  = '0;
            exp_tag   = "R1 reset";
        end else if (in_valid && in_ready) begin
            exp_valid = 1'b1;
            exp_line  = model(in_mode, in_base, in_zmask, in_payload);
            exp_tag   = cur_tag;
        end else begin
            exp_valid = 1'b0;
            exp_tag   = "R10 hold";
        end
        started = 1'b1;
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            checks++;
            if (out_valid !== exp_valid) begin
                errors++;
                $display("FAIL R1 (%s) out_valid actual %0b expected %0b", exp_tag, out_valid, exp_valid);
            end
            checks++;
            if (out_line !== exp_line) begin
                errors++;
                $display("FAIL %s out_line actual %h expected %h", exp_tag, out_line, exp_line);
            end
            if (!rst) begin
                checks++;
                if (in_ready !== 1'b1) begin
                    errors++;
                    $display("FAIL R2 in_ready actual %0b expected 1", in_ready);
                end
            end
        end
    end

    task automatic send(input logic [3:0] m, input logic [63:0] b, input logic [15:0] z,
                        input logic [255:0] p, input string tag);
        @(negedge clk);
        in_valid   = 1'b1;
        in_mode    = m;
        in_base    = b;
        in_zmask   = z;
        in_payload = p;
        cur_tag    = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_mode    = 4'(i + 1);
            in_base    = {$urandom, $urandom};
            in_zmask   = 16'($urandom);
            in_payload = {8{$urandom}};
        end
    endtask

    function automatic logic [255:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R3 zero line, R4 repeated value
        send(4'd0, 64'h1234_5678_9abc_def0, 16'hffff, rnd_line(), "R3 zero");
        send(4'd1, 64'hdead_beef_0bad_f00d, 16'h0000, rnd_line(), "R4 repeat");
        idle(2); // R10 hold with changing inputs

        // R5/R6: each layout with several masks
        for (int m = 2; m <= 7; m++) begin
            send(4'(m), {$urandom, $urandom}, 16'h0000, rnd_line(), "R5 base only");
            send(4'(m), {$urandom, $urandom}, 16'hffff, rnd_line(), "R6 zero base all");
            send(4'(m), {$urandom, $urandom}, 16'h5555, rnd_line(), "R6 mixed mask");
            send(4'(m), {$urandom, $urandom}, 16'($urandom), rnd_line(), "R5 random");
        end

        // R7 wrap and ignored upper base bits
        send(4'd5, 64'h1357_9bdf_ffff_fff0, 16'h0000, {248'd0, 8'h7f}, "R7 wrap 4x1");
        send(4'd7, 64'haaaa_bbbb_cccc_ffff, 16'h0000, {240'd0, 16'h0101}, "R7 wrap 2x1");
        send(4'd2, 64'h0000_0000_0000_0000, 16'h0000, {224'd0, 32'h80ff_0180}, "R7 negative deltas");
        send(4'd4, 64'h7fff_ffff_ffff_ffff, 16'h0000, {128'd0, 128'h0000_0001_7fff_ffff_8000_0000_ffff_ffff}, "R7 8x4 edges");
        send(4'd6, 64'h0, 16'h00ff, {128'd0, {8{16'h8000}}}, "R6 negative immediates");

        // R8 raw, R9 undefined codes
        send(4'd15, 64'h0, 16'h0, rnd_line(), "R8 raw");
        for (int m = 8; m <= 14; m++) send(4'(m), {$urandom, $urandom}, 16'($urandom), rnd_line(), "R9 undefined");
        idle(3); // R10

        // R1 reset in the middle of traffic
        send(4'd15, 64'h0, 16'h0, rnd_line(), "R8 raw before reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        send(4'd3, 64'h0102_0304_0506_0708, 16'h000a, rnd_line(), "R5 after reset");
        idle(2);

        @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule